// File: doc/BRIEF.md
# Receive Descriptor Ring Writer

This block takes an incoming Ethernet frame one byte at a time and spreads it across host memory buffers. Each buffer is described by a 16-byte descriptor in a ring. The descriptor ring starts at `ring_base`. The block keeps its own ring position, which starts at 0 after reset. For each frame it first reads the descriptor at that position and checks that the host has handed it over (the owner bit is set). It then fetches that descriptor's buffer address and writes payload into the buffer. When a buffer fills before the frame ends, the block looks ahead at the next descriptor. If the next descriptor is owned, the frame continues there. If it is not owned, the frame is closed early with error flags. At the end of the frame the block writes back the status and length words. It returns the first descriptor to the host last of all, and then pulses a receive-interrupt flag.

The payload arrives on a valid/ready byte stream with an end-of-frame marker (`in_last`). A byte moves on a clock edge where both `in_valid` and `in_ready` are high. The sender must hold `in_data` and `in_last` steady while `in_valid` is high and `in_ready` is low. The block drops `in_ready` whenever a memory access is pending, so the sender is held off while each byte is written. When a frame is refused, starved or truncated, the block keeps `in_ready` high and takes in and throws away the rest of the frame, up to and including the byte marked last.

The memory side is a master port with one access in flight at a time. An access completes on a clock edge where `mem_req` and `mem_ready` are both high, and read data is taken on that same edge. A descriptor word is read or written with all four byte enables set. A payload byte is written to its word-aligned address with a single byte enable.

Top module: `rx_ring_dma`

## Requirements
- R1: The descriptor at ring position i sits at `ring_base + 16*i`. The position moves on by one each time a descriptor is given up, and it goes back to 0 when it would reach `ring_len`.
- R2: With `layout_sel`=2, a descriptor holds the buffer address at byte offset 0, the flags at 4 and the count at 8. With `layout_sel`=3, the count is at 0 and the buffer address at 8, and the flags stay at 4. With any other value the frame is taken in and discarded, with no memory access and no interrupt.
- R3: Bits 11:0 of the flags word hold the buffer size as a two's-complement negative. The usable byte count is `~(field-1)` kept to 12 bits.
- R4: A frame is accepted only if bit 31 (owner) of the flags word at the current position is 1. Otherwise the frame is taken in and discarded, nothing is written, no interrupt is raised, and the ring position stays the same.
- R5: Each buffer receives bytes in order, starting at its buffer address, until the buffer is full or the frame ends. Each byte is written with the word-aligned address, the byte copied into all four lanes, and one byte enable at `addr[1:0]`.
- R6: Once `MAX_FRAME` bytes are stored, the frame is closed as if it had ended there. The remaining bytes are taken in and dropped.
- R7: The descriptor holding the last byte gets bit 24 (end) set in its flags. Its count word is written as `stored_bytes + 4`, with bits 31:12 at zero.
- R8: When a buffer is full and more bytes are due, the block reads the flags of the next descriptor. If its owner bit is 0, the current descriptor gets bits 30 (error), 26 (no buffer) and 24 (end) set. Its count word is not written, the rest of the frame is dropped, and the ring position is left at that unowned descriptor.
- R9: When a later descriptor is given up, its flags are written back with the owner bit cleared. The first descriptor's flags are written last of all, with the owner bit cleared, bit 25 (start) set, and any end or error bits it collected. All other flag bits keep their read value.
- R10: `rx_int` is high for exactly one cycle, right after the first descriptor's final write completes.
- R11: After reset no access and no stream handshake is pending. While `mem_req` is high and `mem_ready` is low, the request, address, write data, enables and direction stay unchanged.
- R12: `in_ready` is low whenever `mem_req` is high. With `rx_en` low at the start of a frame, the frame is taken in and discarded with no memory access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_en | input | 1 | Allows reception of new frames |
| ring_base | input | AW | Byte address of ring descriptor 0 |
| ring_len | input | IDXW | Number of descriptors in the ring |
| layout_sel | input | 8 | Descriptor word layout: 2 or 3 |
| in_valid | input | 1 | Stream byte valid |
| in_ready | output | 1 | Stream byte accepted |
| in_data | input | 8 | Stream byte |
| in_last | input | 1 | Byte is the last of the frame |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | AW | Word-aligned byte address |
| mem_wdata | output | 32 | Write data |
| mem_be | output | 4 | Byte enables for writes |
| mem_rdata | input | 32 | Read data, taken when the access completes |
| mem_ready | input | 1 | Memory completes the access |
| rx_int | output | 1 | One-cycle receive-interrupt pulse |

## Verification
The assertions take several things for granted about the inputs:
- `ring_base`, `ring_len` and `layout_sel` do not change while a frame is in progress.
- `ring_len` is at least 1.
- Every owned buffer has a size of at least one byte.
- `mem_ready` does not stay low forever.

The bench changes configuration only while the block is idle, between frames, and uses a four-entry ring with non-zero buffer sizes. It stalls memory with a fixed, deterministic pattern of ready cycles, so every request is completed within a few cycles.

// File: rtl/rxr_pkg.sv
package rxr_pkg;
  localparam int unsigned OWN_B  = 31;
  localparam int unsigned ERR_B  = 30;
  localparam int unsigned BUFF_B = 26;
  localparam int unsigned STP_B  = 25;
  localparam int unsigned ENP_B  = 24;
  localparam int unsigned FLD_W  = 12;

  localparam logic [7:0] LAYOUT_PLAIN = 8'd2;
  localparam logic [7:0] LAYOUT_SWAP  = 8'd3;

  typedef enum logic [3:0] {
    S_IDLE, S_RD_OWN, S_RD_BUF, S_FILL, S_WR_BYTE,
    S_RD_NEXT, S_WR_FLG, S_WR_CNT, S_WR_FIRST, S_DRAIN
  } rx_state_e;

  typedef enum logic [1:0] { RT_ADDR, RT_CNT, RT_FIN } flg_ret_e;
endpackage

// File: rtl/rxr_ring_ptr.sv
module rxr_ring_ptr #(
  parameter int IDXW = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            adv,
  input  logic [IDXW-1:0] ring_len,
  output logic [IDXW-1:0] idx,
  output logic [IDXW-1:0] idx_nxt
);
  logic [IDXW-1:0] inc;
  assign inc     = idx + 1'b1;
  assign idx_nxt = (inc == ring_len) ? '0 : inc;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   idx <= '0;
    else if (adv) idx <= idx_nxt;
  end

  AST_IDX_IN_RING: assert property (@(posedge clk) disable iff (!rst_n)
    (ring_len != '0) |-> (idx < ring_len)); // R1
endmodule

// File: rtl/rxr_size_dec.sv
module rxr_size_dec #(
  parameter int FW = 12
) (
  input  logic [FW-1:0] field,
  output logic [FW-1:0] size
);
  // stored as a negative count: usable bytes are the inverse of field-1
  assign size = ~(field - FW'(1));
endmodule

// File: rtl/rxr_ctrl.sv
module rxr_ctrl
  import rxr_pkg::*;
#(
  parameter int AW        = 32,
  parameter int IDXW      = 8,
  parameter int MAX_FRAME = 1518
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rx_en,
  input  logic [AW-1:0]    ring_base,
  input  logic [7:0]       layout_sel,
  input  logic [IDXW-1:0]  idx,
  input  logic [IDXW-1:0]  idx_nxt,
  output logic             adv,
  output logic [FLD_W-1:0] size_field,
  input  logic [FLD_W-1:0] buf_size,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [7:0]       in_data,
  input  logic             in_last,
  output logic             mem_req,
  output logic             mem_we,
  output logic [AW-1:0]    mem_addr,
  output logic [31:0]      mem_wdata,
  output logic [3:0]       mem_be,
  input  logic [31:0]      mem_rdata,
  input  logic             mem_ready,
  output logic             rx_int
);
  localparam int CW = $clog2(MAX_FRAME + 1);

  rx_state_e        st;
  flg_ret_e         ret;
  logic [AW-1:0]    cur_d, first_d, nxt_d, buf_a;
  logic [31:0]      cur_f, first_f, nxt_f;
  logic             is_first, drain_after, last_q;
  logic [7:0]       byte_q;
  logic [FLD_W-1:0] fill, fill_nx;
  logic [CW-1:0]    stored, stored_nx;

  logic          style_ok, swap, done;
  logic [AW-1:0] addr_off, cnt_off, head_d, nxt_head, byte_addr;

  assign style_ok   = (layout_sel == LAYOUT_PLAIN) || (layout_sel == LAYOUT_SWAP);
  assign swap       = (layout_sel == LAYOUT_SWAP);
  assign addr_off   = swap ? AW'(8) : '0;
  assign cnt_off    = swap ? '0 : AW'(8);
  assign head_d     = ring_base + AW'({idx, 4'b0000});
  assign nxt_head   = ring_base + AW'({idx_nxt, 4'b0000});
  assign byte_addr  = buf_a + AW'(fill);
  assign fill_nx    = fill + 1'b1;
  assign stored_nx  = stored + 1'b1;
  assign size_field = cur_f[FLD_W-1:0];
  assign done       = mem_req && mem_ready;
  assign adv        = done && (st == S_RD_NEXT || st == S_WR_CNT);

  always_comb begin
    mem_req   = 1'b0;
    mem_we    = 1'b0;
    mem_addr  = '0;
    mem_wdata = '0;
    mem_be    = 4'hF;
    in_ready  = 1'b0;
    unique case (st)
      S_RD_OWN:  begin mem_req = 1'b1; mem_addr = head_d + AW'(4); end
      S_RD_BUF:  begin mem_req = 1'b1; mem_addr = cur_d + addr_off; end
      S_RD_NEXT: begin mem_req = 1'b1; mem_addr = nxt_head + AW'(4); end
      S_FILL, S_DRAIN: in_ready = 1'b1;
      S_WR_BYTE: begin
        mem_req   = 1'b1;
        mem_we    = 1'b1;
        mem_addr  = {byte_addr[AW-1:2], 2'b00};
        mem_wdata = {4{byte_q}};
        mem_be    = 4'b0001 << byte_addr[1:0];
      end
      S_WR_FLG: begin
        mem_req = 1'b1; mem_we = 1'b1;
        mem_addr = cur_d + AW'(4); mem_wdata = cur_f;
      end
      S_WR_CNT: begin
        mem_req = 1'b1; mem_we = 1'b1;
        mem_addr = cur_d + cnt_off; mem_wdata = 32'(stored) + 32'd4;
      end
      S_WR_FIRST: begin
        mem_req = 1'b1; mem_we = 1'b1;
        mem_addr = first_d + AW'(4);
        mem_wdata = first_f;
        mem_wdata[OWN_B] = 1'b0;
        mem_wdata[STP_B] = 1'b1;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; ret <= RT_FIN;
      cur_d <= '0; first_d <= '0; nxt_d <= '0; buf_a <= '0;
      cur_f <= '0; first_f <= '0; nxt_f <= '0;
      is_first <= 1'b0; drain_after <= 1'b0; last_q <= 1'b0;
      byte_q <= '0; fill <= '0; stored <= '0; rx_int <= 1'b0;
    end else begin
      rx_int <= 1'b0;
      unique case (st)
        S_IDLE: if (in_valid) st <= (rx_en && style_ok) ? S_RD_OWN : S_DRAIN;
        S_RD_OWN: if (done) begin
          if (mem_rdata[OWN_B]) begin
            cur_f <= mem_rdata; first_f <= mem_rdata;
            cur_d <= head_d;    first_d <= head_d;
            is_first <= 1'b1; stored <= '0; drain_after <= 1'b0;
            st <= S_RD_BUF;
          end else st <= S_DRAIN;
        end
        S_RD_BUF: if (done) begin
          buf_a <= mem_rdata[AW-1:0]; fill <= '0; st <= S_FILL;
        end
        S_FILL: if (in_valid) begin
          byte_q <= in_data; last_q <= in_last; st <= S_WR_BYTE;
        end
        S_WR_BYTE: if (done) begin
          fill <= fill_nx; stored <= stored_nx;
          if (last_q || stored_nx == CW'(MAX_FRAME)) begin
            drain_after <= !last_q;
            if (is_first) begin
              first_f[ENP_B] <= 1'b1; st <= S_WR_CNT;
            end else begin
              cur_f[ENP_B] <= 1'b1; cur_f[OWN_B] <= 1'b0;
              ret <= RT_CNT; st <= S_WR_FLG;
            end
          end else if (fill_nx == buf_size) st <= S_RD_NEXT;
          else st <= S_FILL;
        end
        S_RD_NEXT: if (done) begin
          if (mem_rdata[OWN_B]) begin
            nxt_f <= mem_rdata; nxt_d <= nxt_head;
            if (is_first) begin
              cur_f <= mem_rdata; cur_d <= nxt_head; is_first <= 1'b0;
              st <= S_RD_BUF;
            end else begin
              cur_f[OWN_B] <= 1'b0; ret <= RT_ADDR; st <= S_WR_FLG;
            end
          end else begin
            drain_after <= 1'b1;
            if (is_first) begin
              first_f[ERR_B] <= 1'b1; first_f[BUFF_B] <= 1'b1;
              first_f[ENP_B] <= 1'b1; st <= S_WR_FIRST;
            end else begin
              cur_f[ERR_B] <= 1'b1; cur_f[BUFF_B] <= 1'b1;
              cur_f[ENP_B] <= 1'b1; cur_f[OWN_B] <= 1'b0;
              ret <= RT_FIN; st <= S_WR_FLG;
            end
          end
        end
        S_WR_FLG: if (done) begin
          unique case (ret)
            RT_ADDR: begin
              cur_f <= nxt_f; cur_d <= nxt_d; is_first <= 1'b0; st <= S_RD_BUF;
            end
            RT_CNT:  st <= S_WR_CNT;
            default: st <= S_WR_FIRST;
          endcase
        end
        S_WR_CNT: if (done) st <= S_WR_FIRST;
        S_WR_FIRST: if (done) begin
          rx_int <= 1'b1;
          st <= drain_after ? S_DRAIN : S_IDLE;
        end
        S_DRAIN: if (in_valid && in_last) st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ready) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)
      && $stable(mem_wdata) && $stable(mem_be))); // R11
  AST_HOLD_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> !in_ready); // R12
  AST_BYTE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we && mem_be != 4'hF) |-> $onehot(mem_be)); // R5
  AST_INT_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    rx_int |=> !rx_int); // R10
  AST_INT_AFTER_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    rx_int |-> $past(mem_req && mem_we && mem_ready)); // R10
endmodule

// File: rtl/rx_ring_dma.sv
module rx_ring_dma
  import rxr_pkg::*;
#(
  parameter int AW        = 32,
  parameter int IDXW      = 8,
  parameter int MAX_FRAME = 1518
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            rx_en,
  input  logic [AW-1:0]   ring_base,
  input  logic [IDXW-1:0] ring_len,
  input  logic [7:0]      layout_sel,
  input  logic            in_valid,
  output logic            in_ready,
  input  logic [7:0]      in_data,
  input  logic            in_last,
  output logic            mem_req,
  output logic            mem_we,
  output logic [AW-1:0]   mem_addr,
  output logic [31:0]     mem_wdata,
  output logic [3:0]      mem_be,
  input  logic [31:0]     mem_rdata,
  input  logic            mem_ready,
  output logic            rx_int
);
  logic [IDXW-1:0]  idx, idx_nxt;
  logic             adv;
  logic [FLD_W-1:0] size_field, buf_size;

  rxr_ring_ptr #(.IDXW(IDXW)) u_ptr (
    .clk(clk), .rst_n(rst_n), .adv(adv), .ring_len(ring_len),
    .idx(idx), .idx_nxt(idx_nxt)
  );

  rxr_size_dec #(.FW(FLD_W)) u_size (.field(size_field), .size(buf_size));

  rxr_ctrl #(.AW(AW), .IDXW(IDXW), .MAX_FRAME(MAX_FRAME)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .ring_base(ring_base),
    .layout_sel(layout_sel), .idx(idx), .idx_nxt(idx_nxt), .adv(adv),
    .size_field(size_field), .buf_size(buf_size),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data), .in_last(in_last),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_be(mem_be), .mem_rdata(mem_rdata), .mem_ready(mem_ready), .rx_int(rx_int)
  );
endmodule

// File: tb/sim_rx_ring_dma.sv
`timescale 1ns/1ps
module sim_rx_ring_dma;
  localparam int AW = 32, IDXW = 8, MAXF = 48;
  localparam logic [31:0] BASE = 32'h100;
  localparam logic [31:0] INIT_CNT = 32'hDEADBEEF;
  localparam logic [31:0] OWN = 32'h8000_0000, ERR = 32'h4000_0000,
                          BUFF = 32'h0400_0000, STP = 32'h0200_0000, ENP = 32'h0100_0000;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n, rx_en, in_valid, in_ready, in_last, mem_req, mem_we, mem_ready, rx_int;
  logic [AW-1:0] ring_base, mem_addr;
  logic [IDXW-1:0] ring_len;
  logic [7:0] layout_sel, in_data;
  logic [31:0] mem_wdata, mem_rdata;
  logic [3:0] mem_be;

  rx_ring_dma #(.AW(AW), .IDXW(IDXW), .MAX_FRAME(MAXF)) u0 (.*);

  logic [31:0] mem [0:1023];
  int total = 0, bad = 0, wr_cnt = 0, int_cnt = 0, cyc = 0;
  logic stall_en = 1'b0;

  assign mem_ready = !stall_en || (cyc % 3 != 2);
  assign mem_rdata = mem[mem_addr[11:2]];

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (rx_int) int_cnt <= int_cnt + 1;
    if (mem_req && mem_ready && mem_we) begin
      wr_cnt <= wr_cnt + 1;
      for (int b = 0; b < 4; b++)
        if (mem_be[b]) mem[mem_addr[11:2]][8*b +: 8] <= mem_wdata[8*b +: 8];
    end
  end

  initial begin
    wait (cyc > 150000);
    bad++; total++;
    $display("FAIL watchdog expired act=%0d exp<150000", cyc);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] pat(int seed, int k);
    return 8'(seed + k * 7);
  endfunction

  function automatic logic [31:0] fld(int size);
    return 32'((4096 - size) & 12'hFFF);
  endfunction

  function automatic logic [31:0] rdw(logic [31:0] a);
    return mem[a[11:2]];
  endfunction

  function automatic logic [7:0] rdb(logic [31:0] a);
    return mem[a[11:2]][8*a[1:0] +: 8];
  endfunction

  task automatic clear_mem();
    for (int i = 0; i < 1024; i++) mem[i] = '0;
  endtask

  task automatic set_desc(int i, int sty, logic [31:0] bufa, int size, bit own);
    logic [31:0] d;
    d = BASE + 32'(16 * i);
    mem[d[11:2] + 1] = (own ? OWN : 32'h0) | fld(size);
    mem[d[11:2] + 3] = 32'h0;
    if (sty == 3) begin
      mem[d[11:2]] = INIT_CNT; mem[d[11:2] + 2] = bufa;
    end else begin
      mem[d[11:2]] = bufa;     mem[d[11:2] + 2] = INIT_CNT;
    end
  endtask

  task automatic send_frame(int n, int seed);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      in_valid = 1'b1; in_data = pat(seed, k); in_last = (k == n - 1);
      #1;
      while (!in_ready) begin @(negedge clk); #1; end
    end
    @(negedge clk);
    in_valid = 1'b0; in_last = 1'b0;
    repeat (400) @(negedge clk);
  endtask

  function automatic int payload_bad(logic [31:0] a, int n, int seed, int off);
    int e = 0;
    for (int k = 0; k < n; k++) if (rdb(a + 32'(k)) !== pat(seed, off + k)) e++;
    return e;
  endfunction

  task automatic t_reset();
    chk("R11 reset mem_req", 32'(mem_req), 0);
    chk("R11 reset in_ready", 32'(in_ready), 0);
    chk("R10 reset rx_int", 32'(rx_int), 0);
  endtask

  task automatic t_single();
    int i0;
    clear_mem(); set_desc(0, 2, 32'h400, 64, 1); i0 = int_cnt;
    send_frame(20, 1);
    chk("R5 single payload errors", 32'(payload_bad(32'h400, 20, 1, 0)), 0);
    chk("R5 byte past frame untouched", 32'(rdb(32'h414)), 0);
    chk("R9 R7 first flags", rdw(BASE + 4), fld(64) | STP | ENP);
    chk("R7 R2 count at +8", rdw(BASE + 8), 32'd24);
    chk("R10 one interrupt", 32'(int_cnt - i0), 1);
  endtask

  task automatic t_chain();
    clear_mem(); stall_en = 1'b1;
    set_desc(1, 2, 32'h500, 16, 1); set_desc(2, 2, 32'h600, 16, 1);
    set_desc(3, 2, 32'h700, 64, 1);
    send_frame(40, 3);
    stall_en = 1'b0;
    chk("R5 chain buf1", 32'(payload_bad(32'h500, 16, 3, 0)), 0);
    chk("R5 chain buf2", 32'(payload_bad(32'h600, 16, 3, 16)), 0);
    chk("R5 chain buf3", 32'(payload_bad(32'h700, 8, 3, 32)), 0);
    chk("R9 chain first flags", rdw(BASE + 20), fld(16) | STP);
    chk("R9 chain middle flags", rdw(BASE + 36), fld(16));
    chk("R7 chain last flags", rdw(BASE + 52), fld(64) | ENP);
    chk("R7 chain last count", rdw(BASE + 56), 32'd44);
    chk("R7 chain middle count untouched", rdw(BASE + 40), INIT_CNT);
  endtask

  task automatic t_swap();
    clear_mem(); layout_sel = 8'd3;
    set_desc(0, 3, 32'h400, 32, 1);
    send_frame(10, 7);
    layout_sel = 8'd2;
    chk("R1 wrap to 0, payload", 32'(payload_bad(32'h400, 10, 7, 0)), 0);
    chk("R2 style3 count at +0", rdw(BASE), 32'd14);
    chk("R2 style3 addr word kept", rdw(BASE + 8), 32'h400);
    chk("R3 style3 flags", rdw(BASE + 4), fld(32) | STP | ENP);
  endtask

  task automatic t_not_owned();
    int w0, i0;
    clear_mem(); set_desc(1, 2, 32'h500, 64, 0); w0 = wr_cnt; i0 = int_cnt;
    send_frame(8, 2);
    chk("R4 no writes when not owned", 32'(wr_cnt - w0), 0);
    chk("R4 no interrupt when not owned", 32'(int_cnt - i0), 0);
    set_desc(1, 2, 32'h500, 64, 1);
    send_frame(5, 4);
    chk("R4 position kept, payload lands in desc1", 32'(payload_bad(32'h500, 5, 4, 0)), 0);
    chk("R4 desc1 flags", rdw(BASE + 20), fld(64) | STP | ENP);
  endtask

  task automatic t_starve();
    int i0;
    clear_mem(); set_desc(2, 2, 32'h600, 8, 1); set_desc(3, 2, 32'h700, 64, 0);
    i0 = int_cnt;
    send_frame(20, 5);
    chk("R8 starved flags", rdw(BASE + 36), fld(8) | STP | ENP | ERR | BUFF);
    chk("R8 count not written", rdw(BASE + 40), INIT_CNT);
    chk("R8 buffer bytes", 32'(payload_bad(32'h600, 8, 5, 0)), 0);
    chk("R8 no overrun", 32'(rdb(32'h608)), 0);
    chk("R8 unowned desc untouched", rdw(BASE + 52), fld(64));
    chk("R10 starve interrupt", 32'(int_cnt - i0), 1);
  endtask

  task automatic t_trunc();
    clear_mem(); set_desc(3, 2, 32'h700, 128, 1);
    send_frame(60, 9);
    chk("R8 position left on unowned desc, R6 payload", 32'(payload_bad(32'h700, 48, 9, 0)), 0);
    chk("R6 nothing past limit", 32'(rdb(32'h730)), 0);
    chk("R6 truncated count", rdw(BASE + 56), 32'd52);
    chk("R6 flags", rdw(BASE + 52), fld(128) | STP | ENP);
  endtask

  task automatic t_refuse();
    int w0, i0;
    clear_mem(); set_desc(0, 2, 32'h400, 64, 1);
    w0 = wr_cnt; i0 = int_cnt;
    layout_sel = 8'd5;
    send_frame(6, 1);
    chk("R2 invalid style no writes", 32'(wr_cnt - w0), 0);
    layout_sel = 8'd2; rx_en = 1'b0;
    send_frame(6, 1);
    rx_en = 1'b1;
    chk("R12 disabled no writes", 32'(wr_cnt - w0), 0);
    chk("R12 disabled no interrupt", 32'(int_cnt - i0), 0);
    chk("R2 desc untouched", rdw(BASE + 4), OWN | fld(64));
  endtask

  task automatic t_exact();
    clear_mem(); set_desc(0, 2, 32'h803, 12, 1); set_desc(1, 2, 32'h500, 64, 0);
    send_frame(12, 11);
    chk("R5 unaligned payload", 32'(payload_bad(32'h803, 12, 11, 0)), 0);
    chk("R5 byte before buffer", 32'(rdb(32'h802)), 0);
    chk("R5 byte after buffer", 32'(rdb(32'h80F)), 0);
    chk("R3 R7 exact fit flags no error", rdw(BASE + 4), fld(12) | STP | ENP);
    chk("R7 exact fit count", rdw(BASE + 8), 32'd16);
  endtask

  initial begin
    rst_n = 1'b0; rx_en = 1'b1; ring_base = BASE; ring_len = 8'd4; layout_sel = 8'd2;
    in_valid = 1'b0; in_data = '0; in_last = 1'b0;
    clear_mem();
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_single();
    t_chain();
    t_swap();
    t_not_owned();
    t_starve();
    t_trunc();
    t_refuse();
    t_exact();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule